// File: doc/BRIEF.md
# Ping-Pong Receive DMA Buffer Manager

This block looks after two receive buffers in system memory, called A and B, for a single serial channel. The host programs each buffer with a base address and a byte limit, then hands it over by setting an ownership bit in that buffer's status register. While the block owns a buffer, the host cannot change it. Incoming frame bytes are written one at a time through a simple memory write port. A shared current-address pointer follows the write position.

A channel status register shows whether a frame is in progress and which buffer the next frame will use. The next-buffer flag flips as soon as the first byte of a frame arrives, so the host can refill the other buffer while a frame is still being received. When the frame ends, the block does three things to the buffer it used:

- It replaces the limit in the count register with the number of bytes actually stored.
- It sets the end-of-buffer and end-of-frame status bits, and also the CRC-error and overrun bits when they apply.
- It clears ownership, which returns the buffer to the host.

Framing and CRC checking happen upstream. This block receives only the frame-end and CRC-good indications.

Top module: `rx_pingpong_dma`

## Requirements
- R1: After reset every register reads zero. The host register map (reg_addr) is: 0 A base, 1 A count, 2 A status, 3 B base, 4 B count, 5 B status, 6 current address (read only), 7 channel status (read only: bit 0 busy, bit 1 next buffer, where 0 means A and 1 means B). A write to an unowned buffer register is read back unchanged.
- R2: Host writes to the base, count or status register of a buffer whose status bit 0 (ownership) is 1 have no effect.
- R3: The busy flag rises on the cycle after the first byte of a frame is accepted from the input. The frame goes to the buffer named by the next-buffer flag, and that flag inverts on the same edge that sets busy.
- R4: Each stored byte appears on the memory port one cycle after it is presented. Stored bytes go to consecutive addresses starting at the buffer base. The current-address register then holds the address after the last write.
- R5: On frame end with an owned buffer, several things update together: the count register takes the number of stored bytes, status bits 1 (end of buffer) and 2 (end of frame) are set, bit 0 is cleared, status bits 7..5 are kept, and busy falls.
- R6: A frame that ends with CRC-good low sets status bit 3 of its buffer. Otherwise bit 3 is cleared.
- R7: Bytes beyond the programmed count limit are not written. Such a frame ends with status bit 4 (overrun) set and a count equal to the limit.
- R8: If a frame starts while the selected buffer is unowned, none of its bytes are written. Status bit 4 of that buffer is set, the buffer's count, ownership and the current address stay unchanged, and the next-buffer flag still inverts.
- R9: A frame-end pulse with no frame in progress and no byte has no effect. A frame-end pulse that arrives together with a byte includes that byte, so a one-byte frame is a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 3 | Host register index for both read and write |
| reg_wdata | input | ADDR_W | Host write data |
| reg_rdata | output | ADDR_W | Combinational read data for reg_addr |
| rx_valid | input | 1 | A received byte is present |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | Frame ends this cycle (the delimiter has been seen) |
| rx_crc_ok | input | 1 | CRC result qualifying rx_end |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write byte address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The bench builds the block with its default parameters: a 32-bit address and a 16-bit count. It programs limits of only a few bytes, so the overrun-on-limit path and the count writeback are both reached after a handful of input cycles. The ping-pong sequence alternates between A and B. This covers a frame into a buffer the host has not re-armed, a frame-end pulse with no frame in progress, and a single-cycle frame in which the byte and the frame end coincide.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

    localparam int STAT_W = 8;

    // status bit positions
    localparam int ST_OWN = 0;
    localparam int ST_EOB = 1;
    localparam int ST_EOF = 2;
    localparam int ST_CRC = 3;
    localparam int ST_OVR = 4;

    typedef enum logic [2:0] {
        RG_A_BASE  = 3'd0,
        RG_A_COUNT = 3'd1,
        RG_A_STAT  = 3'd2,
        RG_B_BASE  = 3'd3,
        RG_B_COUNT = 3'd4,
        RG_B_STAT  = 3'd5,
        RG_CUR     = 3'd6,
        RG_CHAN    = 3'd7
    } reg_sel_e;

    // per-buffer event from the frame engine
    typedef struct packed {
        logic done;      // frame closed into an owned buffer
        logic crc_err;
        logic ovr;
        logic ovr_mark;  // frame began on an unowned buffer
    } buf_evt_t;

    function automatic logic [STAT_W-1:0] close_status(
        input logic [STAT_W-1:0] old,
        input logic              crc_err,
        input logic              ovr
    );
        logic [STAT_W-1:0] s;
        s         = old;
        s[ST_OWN] = 1'b0;
        s[ST_EOB] = 1'b1;
        s[ST_EOF] = 1'b1;
        s[ST_CRC] = crc_err;
        s[ST_OVR] = ovr;
        return s;
    endfunction

endpackage

// File: rtl/rxdma_bufregs.sv
module rxdma_bufregs
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_base,
    input  logic              wr_count,
    input  logic              wr_stat,
    input  logic [ADDR_W-1:0] wdata,
    input  buf_evt_t          evt,
    input  logic [CNT_W-1:0]  fin_cnt,
    output logic [ADDR_W-1:0] base_q,
    output logic [CNT_W-1:0]  count_q,
    output logic [STAT_W-1:0] stat_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            count_q <= '0;
            stat_q  <= '0;
        end else if (evt.done) begin
            count_q <= fin_cnt;
            stat_q  <= close_status(stat_q, evt.crc_err, evt.ovr);
        end else if (evt.ovr_mark) begin
            stat_q[ST_OVR] <= 1'b1;
        end else if (!stat_q[ST_OWN]) begin
            if (wr_base)  base_q  <= wdata;
            if (wr_count) count_q <= wdata[CNT_W-1:0];
            if (wr_stat)  stat_q  <= wdata[STAT_W-1:0];
        end
    end

    AST_OWNED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        stat_q[ST_OWN] && !evt.done |=> $stable(base_q) && $stable(count_q)); // R2

    AST_RETURN_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        evt.done |=> !stat_q[ST_OWN] && stat_q[ST_EOF] && stat_q[ST_EOB]); // R5

endmodule

// File: rtl/rxdma_engine.sv
module rxdma_engine
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rx_valid,
    input  logic [7:0]             rx_data,
    input  logic                   rx_end,
    input  logic                   rx_crc_ok,
    input  logic [1:0]             own,
    input  logic [1:0][ADDR_W-1:0] base,
    input  logic [1:0][CNT_W-1:0]  limit,
    output buf_evt_t [1:0]         evt,
    output logic [CNT_W-1:0]       fin_cnt,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    output logic [ADDR_W-1:0]      cur_addr,
    output logic                   busy,
    output logic                   next_buf
);

    logic             act, drop_all, ovr;
    logic [CNT_W-1:0] cnt;

    logic              sel, owned, accept, spill, starting, ending, ovr_nx;
    logic [CNT_W-1:0]  cnt_base, cnt_nx;
    logic [ADDR_W-1:0] wr_ptr;

    always_comb begin
        starting = !busy && rx_valid;
        sel      = busy ? act : next_buf;
        owned    = busy ? !drop_all : own[sel];
        cnt_base = busy ? cnt : '0;
        wr_ptr   = busy ? cur_addr : base[sel];
        accept   = rx_valid && owned && (cnt_base < limit[sel]);
        spill    = rx_valid && owned && !(cnt_base < limit[sel]);
        ending   = rx_end && (busy || rx_valid);
        ovr_nx   = (busy && ovr) || spill;
        cnt_nx   = cnt_base + CNT_W'(accept);
        fin_cnt  = cnt_nx;
        for (int b = 0; b < 2; b++) begin
            evt[b].done     = ending && owned && (sel == 1'(b));
            evt[b].crc_err  = !rx_crc_ok;
            evt[b].ovr      = ovr_nx;
            evt[b].ovr_mark = starting && !own[sel] && (sel == 1'(b));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act       <= 1'b0;
            drop_all  <= 1'b0;
            ovr       <= 1'b0;
            cnt       <= '0;
            busy      <= 1'b0;
            next_buf  <= 1'b0;
            cur_addr  <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= accept;
            if (accept) begin
                mem_addr  <= wr_ptr;
                mem_wdata <= rx_data;
                cur_addr  <= wr_ptr + 1'b1;
            end
            cnt <= cnt_nx;
            ovr <= ovr_nx;
            if (starting) begin
                act      <= next_buf;
                next_buf <= !next_buf;
                drop_all <= !own[sel];
            end
            busy <= (busy || starting) && !ending;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        busy && !drop_all |-> cnt <= limit[act]); // R7

    AST_PTR_CONTINUES: assert property (@(posedge clk) disable iff (rst)
        busy && accept |=> mem_we && mem_addr == $past(cur_addr)); // R4

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        starting && !own[sel] |=> !mem_we); // R8

    AST_FLAG_FLIP: assert property (@(posedge clk) disable iff (rst)
        starting |=> next_buf != $past(next_buf)); // R3

    AST_BUSY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ending |=> !busy); // R5

    AST_IDLE_END_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy && !rx_valid |=> !busy && !mem_we); // R9

endmodule

// File: rtl/rx_pingpong_dma.sv
module rx_pingpong_dma
    import rxdma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              rx_crc_ok,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);

    localparam int NBUF = 2;

    logic [NBUF-1:0][ADDR_W-1:0] base_vec;
    logic [NBUF-1:0][CNT_W-1:0]  cnt_vec;
    logic [NBUF-1:0][STAT_W-1:0] stat_vec;
    logic [NBUF-1:0]             own_vec;
    buf_evt_t [NBUF-1:0]         evt;
    logic [CNT_W-1:0]            fin_cnt;
    logic [ADDR_W-1:0]           cur_addr;
    logic                        busy, next_buf;

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        localparam logic [2:0] BASE_IDX = 3'(g * 3);

        rxdma_bufregs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr_base  (reg_wr_en && reg_addr == BASE_IDX),
            .wr_count (reg_wr_en && reg_addr == BASE_IDX + 3'd1),
            .wr_stat  (reg_wr_en && reg_addr == BASE_IDX + 3'd2),
            .wdata    (reg_wdata),
            .evt      (evt[g]),
            .fin_cnt  (fin_cnt),
            .base_q   (base_vec[g]),
            .count_q  (cnt_vec[g]),
            .stat_q   (stat_vec[g])
        );

        assign own_vec[g] = stat_vec[g][ST_OWN];
    end

    rxdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_end    (rx_end),
        .rx_crc_ok (rx_crc_ok),
        .own       (own_vec),
        .base      (base_vec),
        .limit     (cnt_vec),
        .evt       (evt),
        .fin_cnt   (fin_cnt),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .cur_addr  (cur_addr),
        .busy      (busy),
        .next_buf  (next_buf)
    );

    always_comb begin
        case (reg_sel_e'(reg_addr))
            RG_A_BASE:  reg_rdata = base_vec[0];
            RG_A_COUNT: reg_rdata = ADDR_W'(cnt_vec[0]);
            RG_A_STAT:  reg_rdata = ADDR_W'(stat_vec[0]);
            RG_B_BASE:  reg_rdata = base_vec[1];
            RG_B_COUNT: reg_rdata = ADDR_W'(cnt_vec[1]);
            RG_B_STAT:  reg_rdata = ADDR_W'(stat_vec[1]);
            RG_CUR:     reg_rdata = cur_addr;
            default:    reg_rdata = ADDR_W'({next_buf, busy});
        endcase
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $countones({evt[0].done, evt[1].done, evt[0].ovr_mark, evt[1].ovr_mark}) <= 1); // R5

endmodule

// File: tb/rx_pingpong_dma_bench.sv
`timescale 1ns/1ps
module rx_pingpong_dma_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_end = 1'b0;
    logic        rx_crc_ok = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    rx_pingpong_dma u_rx_pingpong_dma (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_base [2];
    int          m_lim  [2];
    logic [7:0]  m_stat [2];
    bit          m_busy, m_next, m_act, m_drop, m_ovr;
    int          m_cnt;
    logic [31:0] m_cur;
    bit          m_we;
    logic [31:0] m_wa;
    logic [7:0]  m_wd;

    int          t_sel, t_cnt, t_done, t_mark, t_b, t_f;
    bit          t_own, t_spill, t_ovr, t_end;
    logic [31:0] t_ptr;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2; i++) begin
                m_base[i] = '0; m_lim[i] = 0; m_stat[i] = '0;
            end
            m_busy = 0; m_next = 0; m_act = 0; m_drop = 0; m_ovr = 0;
            m_cnt = 0; m_cur = '0; m_we = 0; m_wa = '0; m_wd = '0;
        end else begin
            t_sel   = m_busy ? int'(m_act) : int'(m_next);
            t_own   = m_busy ? !m_drop : m_stat[t_sel][0];
            t_cnt   = m_busy ? m_cnt : 0;
            t_ptr   = m_busy ? m_cur : m_base[t_sel];
            t_spill = 0;
            m_we    = 0;
            if (rx_valid && t_own) begin
                if (t_cnt < m_lim[t_sel]) begin
                    m_we = 1; m_wa = t_ptr; m_wd = rx_data;
                    m_cur = t_ptr + 32'd1;
                    t_cnt++;
                end else t_spill = 1;
            end
            t_ovr  = (m_busy && m_ovr) || t_spill;
            t_end  = rx_end && (m_busy || rx_valid);
            t_done = (t_end && t_own) ? t_sel : -1;
            t_mark = (!m_busy && rx_valid && !m_stat[t_sel][0]) ? t_sel : -1;
            if (reg_wr_en && reg_addr < 3'd6) begin
                t_b = int'(reg_addr) / 3;
                t_f = int'(reg_addr) % 3;
                if (!m_stat[t_b][0] && t_b != t_done && t_b != t_mark) begin
                    if (t_f == 0) m_base[t_b] = reg_wdata;
                    else if (t_f == 1) m_lim[t_b] = int'(reg_wdata[15:0]);
                    else m_stat[t_b] = reg_wdata[7:0];
                end
            end
            if (t_done >= 0) begin
                m_lim[t_done]  = t_cnt;
                m_stat[t_done] = (m_stat[t_done] & 8'hE0) | 8'h06
                               | (t_ovr ? 8'h10 : 8'h00) | (rx_crc_ok ? 8'h00 : 8'h08);
            end
            if (t_mark >= 0) m_stat[t_mark] = m_stat[t_mark] | 8'h10;
            if (!m_busy && rx_valid) begin
                m_act = m_next; m_next = !m_next; m_drop = !t_own; m_busy = 1;
            end
            if (t_end) m_busy = 0;
            m_cnt = t_cnt;
            m_ovr = t_ovr;
        end
    end

    // compare memory port on every clock, away from the edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (mem_we !== m_we || (m_we && (mem_addr !== m_wa || mem_wdata !== m_wd))) begin
                errors++;
                $display("FAIL R4 mem port: we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                         mem_we, mem_addr, mem_wdata, m_we, m_wa, m_wd);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic host_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rx_cycle(input bit v, input logic [7:0] b, input bit e, input bit ok);
        @(negedge clk);
        rx_valid = v; rx_data = b; rx_end = e; rx_crc_ok = ok;
    endtask

    task automatic rx_idle();
        @(negedge clk);
        rx_valid = 1'b0; rx_end = 1'b0; rx_crc_ok = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s reg %0d: got %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 8; a++) peek(3'(a), 32'h0, "R1");

        // R1 program buffer A
        host_wr(3'd0, 32'h0000_1000);
        host_wr(3'd1, 32'd4);
        host_wr(3'd2, 32'h0000_0001);
        peek(3'd0, 32'h0000_1000, "R1");
        peek(3'd1, 32'd4, "R1");
        // R2 owned buffer ignores host writes
        host_wr(3'd0, 32'h0000_2222);
        host_wr(3'd1, 32'd99);
        host_wr(3'd2, 32'h0000_0000);
        peek(3'd0, 32'h0000_1000, "R2");
        peek(3'd1, 32'd4, "R2");
        peek(3'd2, 32'h1, "R2");

        // R3/R4/R5 three-byte frame into A
        rx_cycle(1, 8'h11, 0, 0);
        rx_cycle(1, 8'h22, 0, 0);
        peek(3'd7, 32'h3, "R3");
        rx_cycle(1, 8'h33, 1, 1);
        rx_idle();
        peek(3'd1, 32'd3, "R5");
        peek(3'd2, 32'h06, "R5");
        peek(3'd7, 32'h2, "R5");
        peek(3'd6, 32'h0000_1003, "R4");

        // R6/R7 buffer B with limit 2, four bytes, bad CRC, separate end
        host_wr(3'd3, 32'h0000_2000);
        host_wr(3'd4, 32'd2);
        host_wr(3'd5, 32'h0000_0001);
        rx_cycle(1, 8'hA0, 0, 0);
        rx_cycle(1, 8'hA1, 0, 0);
        rx_cycle(1, 8'hA2, 0, 0);
        rx_cycle(1, 8'hA3, 0, 0);
        rx_cycle(0, 8'h00, 1, 0);
        rx_idle();
        peek(3'd4, 32'd2, "R7");
        peek(3'd5, 32'h1E, "R6");
        peek(3'd6, 32'h0000_2002, "R7");
        peek(3'd7, 32'h0, "R3");

        // R8 frame onto returned (unowned) buffer A
        rx_cycle(1, 8'hC0, 0, 0);
        rx_cycle(1, 8'hC1, 1, 1);
        rx_idle();
        peek(3'd2, 32'h16, "R8");
        peek(3'd1, 32'd3, "R8");
        peek(3'd6, 32'h0000_2002, "R8");
        peek(3'd7, 32'h2, "R8");

        // R9 lone frame-end pulse in idle
        rx_cycle(0, 8'h00, 1, 1);
        rx_idle();
        peek(3'd7, 32'h2, "R9");
        peek(3'd2, 32'h16, "R9");
        peek(3'd5, 32'h1E, "R9");

        // R9 single-cycle frame into re-armed B
        host_wr(3'd3, 32'h0000_3000);
        host_wr(3'd4, 32'd8);
        host_wr(3'd5, 32'h0000_0001);
        peek(3'd3, 32'h0000_3000, "R1");
        rx_cycle(1, 8'h5A, 1, 1);
        rx_idle();
        peek(3'd4, 32'd1, "R9");
        peek(3'd5, 32'h06, "R9");
        peek(3'd6, 32'h0000_3001, "R9");
        peek(3'd7, 32'h0, "R9");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule